// File: doc/BRIEF.md
# Scaling-Free Rotation Stage

This block performs a single micro-rotation of a rotation-mode coordinate rotator that needs no gain correction. A signed 16-bit coordinate pair (x, y) arrives together with a shift value s. The pair leaves rotated counter-clockwise by the elementary angle 2^-s radians. Cosine and sine come from a truncated Taylor series in which the cubic coefficient 1/6 becomes 1/8. Each term is therefore an arithmetic right shift of an operand, and the rotation has unit gain without any multiplier.

A surrounding controller chooses the shift sequence and counts the iterations. It feeds the result of one pass back in for the next. An iteration with no angle left is passed through by asserting the skip input. The stage has a latency of exactly one clock and accepts a new operand on every cycle.

Top module: `sfc_rot_stage`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid, out_x and out_y become 0 at that edge.
- R2: out_valid equals the in_valid seen at the preceding rising clock edge, so back-to-back operands come out on consecutive cycles.
- R3: For a valid operand with skip low, out_x = sat(x - F(x, 2s+1) - (F(y, s) - F(y, 3s+3))). F(v, n) is v shifted right arithmetically by n, which rounds toward negative infinity. sat clamps to the signed 16-bit range. The legal shifts are 2 to 15.
- R4: For a valid operand with skip low, out_y = sat(y - F(y, 2s+1) + (F(x, s) - F(x, 3s+3))). A positive x with y = 0 therefore never gives a negative out_y.
- R5: For a valid operand with skip high, out_x = x and out_y = y, whatever the shift is.
- R6: A result above 32767 leaves as 32767, and a result below -32768 leaves as -32768.
- R7: While in_valid is low, out_x and out_y keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_x | input | 16 | Signed x coordinate |
| in_y | input | 16 | Signed y coordinate |
| in_shift | input | 4 | Shift s; the rotation angle is 2^-s rad |
| in_skip | input | 1 | Pass the coordinates through unrotated |
| out_valid | output | 1 | Result present |
| out_x | output | 16 | Rotated, saturated x |
| out_y | output | 16 | Rotated, saturated y |

## Verification
The assertions assume one thing about the inputs: a valid operand that is not skipped carries a shift of at least 2. Below that shift the truncated series loses accuracy, so the stage guarantees only the arithmetic for shifts of 2 and above. Every rotating stimulus uses shifts from 2 to 15. Shifts of 0 and 1 appear only on skipped operands, where R5 says the shift has no effect. The skipped operands confirm that such shifts change nothing at the outputs.

// File: rtl/sfc_pkg.sv
// Shared definitions for the scaling-free rotation stage.
// Assumes nothing beyond the two-lane (x, y) organisation of the datapath.
package sfc_pkg;
    typedef enum int {LANE_X = 0, LANE_Y = 1} lane_e;
    localparam int NUM_LANES = 2;
    localparam int DEF_GUARD = 2;
endpackage

// File: rtl/sfc_cos_term.sv
// Cosine product: v*(1 - a^2/2) with a = 2^-s, formed as v - (v >>> (2s+1)).
// Assumes v is already sign-extended with guard bits, so that no overflow can occur.
module sfc_cos_term #(
    parameter int W       = 18,
    parameter int SHIFT_W = 4
) (
    input  logic signed [W-1:0]       v,
    input  logic        [SHIFT_W-1:0] s,
    output logic signed [W-1:0]       res
);
    localparam int AMT_W = SHIFT_W + 2;
    logic [AMT_W-1:0] amt;

    // Shift amount for the square term, then the subtraction.
    always_comb begin
        amt = (AMT_W'(s) << 1) + AMT_W'(1);
        res = v - (v >>> amt);
    end
endmodule

// File: rtl/sfc_sin_term.sv
// Sine product: v*(a - a^3/8) with a = 2^-s, formed as (v >>> s) - (v >>> (3s+3)).
// Assumes a sign-extended operand. An oversized shift fills with the sign bit.
module sfc_sin_term #(
    parameter int W       = 18,
    parameter int SHIFT_W = 4
) (
    input  logic signed [W-1:0]       v,
    input  logic        [SHIFT_W-1:0] s,
    output logic signed [W-1:0]       res
);
    localparam int AMT_W = SHIFT_W + 2;
    logic [AMT_W-1:0] amt3;

    // Shift amount for the cubic term, then the difference of the two shifted copies.
    always_comb begin
        amt3 = AMT_W'(s) * AMT_W'(3) + AMT_W'(3);
        res  = (v >>> s) - (v >>> amt3);
    end
endmodule

// File: rtl/sfc_sat.sv
// Clamps a wide signed value into OUT_W bits.
// Assumes IN_W > OUT_W.
module sfc_sat #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  v,
    output logic signed [OUT_W-1:0] res
);
    logic fits;

    // The value fits when every bit above the output sign bit copies that sign bit.
    always_comb begin
        fits = (&v[IN_W-1:OUT_W-1]) | ~(|v[IN_W-1:OUT_W-1]);
        if (fits)
            res = v[OUT_W-1:0];
        else if (v[IN_W-1])
            res = {1'b1, {(OUT_W-1){1'b0}}};
        else
            res = {1'b0, {(OUT_W-1){1'b1}}};
    end
endmodule

// File: rtl/sfc_rot_stage.sv
// One micro-rotation of a scaling-free rotator. The lanes are cross-coupled through
// the cosine and sine shift-add terms, saturated, and registered once.
// Assumes the shift is at least 2 on non-skipped operands. No back-pressure.
module sfc_rot_stage #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = sfc_pkg::DEF_GUARD,
    parameter int SHIFT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_x,
    input  logic signed [DATA_W-1:0] in_y,
    input  logic [SHIFT_W-1:0]       in_shift,
    input  logic                     in_skip,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_x,
    output logic signed [DATA_W-1:0] out_y
);
    import sfc_pkg::*;
    localparam int W = DATA_W + GUARD_W;

    logic signed [W-1:0]      lane_in  [NUM_LANES];
    logic signed [W-1:0]      cos_out  [NUM_LANES];
    logic signed [W-1:0]      sin_out  [NUM_LANES];
    logic signed [W-1:0]      lane_sum [NUM_LANES];
    logic signed [DATA_W-1:0] lane_sat [NUM_LANES];

    // Sign-extend both coordinates into the guarded width.
    always_comb begin
        lane_in[LANE_X] = {{GUARD_W{in_x[DATA_W-1]}}, in_x};
        lane_in[LANE_Y] = {{GUARD_W{in_y[DATA_W-1]}}, in_y};
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sfc_cos_term #(.W(W), .SHIFT_W(SHIFT_W)) u_cos (
            .v(lane_in[g]), .s(in_shift), .res(cos_out[g]));
        sfc_sin_term #(.W(W), .SHIFT_W(SHIFT_W)) u_sin (
            .v(lane_in[g]), .s(in_shift), .res(sin_out[g]));
        sfc_sat #(.IN_W(W), .OUT_W(DATA_W)) u_sat (
            .v(lane_sum[g]), .res(lane_sat[g]));
    end

    // Cross-coupled update: x uses -sin(y) and y uses +sin(x).
    always_comb begin
        lane_sum[LANE_X] = cos_out[LANE_X] - sin_out[LANE_Y];
        lane_sum[LANE_Y] = cos_out[LANE_Y] + sin_out[LANE_X];
    end

    // Result register with a skip bypass; the outputs hold while no operand arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_x <= in_skip ? in_x : lane_sat[LANE_X];
                out_y <= in_skip ? in_y : lane_sat[LANE_Y];
            end
        end
    end
endmodule

// File: rtl/sfc_rot_stage_chk.sv
// Property checker for sfc_rot_stage, bound to every instance.
module sfc_rot_stage_chk #(
    parameter int DATA_W    = 16,
    parameter int SHIFT_W   = 4,
    parameter int MIN_SHIFT = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_x,
    input logic signed [DATA_W-1:0] in_y,
    input logic [SHIFT_W-1:0]       in_shift,
    input logic                     in_skip,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_x,
    input logic signed [DATA_W-1:0] out_y
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_x == '0 && out_y == '0));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_shift_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_skip) |-> (int'(in_shift) >= MIN_SHIFT));

    p_pos_sine_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_skip && in_y == '0 && in_x > 0) |=> (out_y >= 0));

    p_skip_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_skip) |=> (out_x == $past(in_x) && out_y == $past(in_y)));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_x) && $stable(out_y)));
endmodule

bind sfc_rot_stage sfc_rot_stage_chk #(
    .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .MIN_SHIFT(2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_shift(in_shift), .in_skip(in_skip), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y)
);

// File: tb/sfc_rot_stage_tb.sv
`timescale 1ns/1ps
module sfc_rot_stage_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_x = '0;
    logic signed [15:0] in_y = '0;
    logic [3:0]        in_shift = 4'd2;
    logic              in_skip = 1'b0;
    logic              out_valid;
    logic signed [15:0] out_x;
    logic signed [15:0] out_y;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sfc_rot_stage u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_shift(in_shift), .in_skip(in_skip), .out_valid(out_valid),
        .out_x(out_x), .out_y(out_y));

    localparam int NV = 8;
    localparam int VX [NV] = '{1000, 0, -1000, -32768, 32767, 12345, -1, 20000};
    localparam int VY [NV] = '{0, 1000, 500, -32768, -32768, -6789, -1, 20000};
    localparam int VS [NV] = '{2, 3, 2, 2, 2, 5, 2, 15};

    function automatic longint fl(longint v, int n);
        if (n >= 62) return (v < 0) ? -1 : 0;
        return v >>> n;
    endfunction

    function automatic int sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int ref_x(int x, int y, int s);
        return sat16(longint'(x) - fl(x, 2*s+1) - (fl(y, s) - fl(y, 3*s+3)));
    endfunction

    function automatic int ref_y(int x, int y, int s);
        return sat16(longint'(y) - fl(y, 2*s+1) + (fl(x, s) - fl(x, 3*s+3)));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one operand for one cycle, then sample at the next falling edge.
    task automatic apply(int x, int y, int s, bit skip);
        @(negedge clk);
        in_valid = 1'b1; in_x = 16'(x); in_y = 16'(y);
        in_shift = 4'(s); in_skip = skip;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 x", int'(out_x), 0);
        chk("R1 y", int'(out_y), 0);
        @(negedge clk); rst_n = 1'b1;

        // R3 R4 R2: vector table
        for (int i = 0; i < NV; i++) begin
            apply(VX[i], VY[i], VS[i], 1'b0);
            chk("R2 valid", int'(out_valid), 1);
            chk("R3 x", int'(out_x), ref_x(VX[i], VY[i], VS[i]));
            chk("R4 y", int'(out_y), ref_y(VX[i], VY[i], VS[i]));
        end

        // R3 R4: -1 rounds toward negative infinity, so both terms cancel to 0
        apply(-1, -1, 2, 1'b0);
        chk("R3 floor x", int'(out_x), 0);
        chk("R4 floor y", int'(out_y), 0);

        // R6: saturation at the positive limit, with the other lane unclamped
        apply(32767, -32768, 2, 1'b0);
        chk("R6 sat x", int'(out_x), 32767);
        chk("R6 y", int'(out_y), -23616);
        // R6: saturation at the negative limit
        apply(-32768, 32767, 2, 1'b0);
        chk("R6 sat neg x", int'(out_x), -32768);

        // R5: skip passes the pair through, even with shift 0
        apply(1234, -4321, 0, 1'b1);
        chk("R5 x", int'(out_x), 1234);
        chk("R5 y", int'(out_y), -4321);

        // R7: idle cycles hold the outputs and drop valid
        @(negedge clk);
        in_x = 16'sd999; in_y = 16'sd999;
        @(negedge clk);
        chk("R7 x", int'(out_x), 1234);
        chk("R7 y", int'(out_y), -4321);
        chk("R2 idle", int'(out_valid), 0);

        // R2: back-to-back operands, one result per cycle
        @(negedge clk);
        in_valid = 1'b1; in_skip = 1'b0;
        in_x = 16'sd5000; in_y = 16'sd3000; in_shift = 4'd4;
        @(negedge clk);
        chk("R2 b2b v0", int'(out_valid), 1);
        chk("R3 b2b x0", int'(out_x), ref_x(5000, 3000, 4));
        in_x = -16'sd7000; in_y = 16'sd100; in_shift = 4'd3;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b v1", int'(out_valid), 1);
        chk("R4 b2b y1", int'(out_y), ref_y(-7000, 100, 3));

        // R1: reset in mid-run clears the outputs
        apply(3000, 3000, 2, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid valid", int'(out_valid), 0);
        chk("R1 mid x", int'(out_x), 0);
        rst_n = 1'b1;

        done = 1;
        finish_run();
    end
endmodule